// File: doc/BRIEF.md
# Three-Level Minimum-Transition Pulse Sequencer

The block takes the three switching states chosen for one modulation period, together with their on-times in clock ticks, and plays them out on three phase outputs. Each phase output is a three-level command: positive rail, mid point or negative rail. A period-start strobe latches the state set, the on-times and the period length. The block then runs a counter through a five-segment pattern that is mirrored about the period centre.

Each state has a vector number, which is the sum of its three phase codes. The states are ordered by this number, so every step inside a period moves exactly one phase by one level. The two outer states of that order are the candidates for the split end segments. The block picks the candidate equal to the state that closed the previous period, so nothing switches at the period boundary. When neither candidate matches, it takes the one nearest in vector number and raises a flag for that whole period.

The controller has three states. `ST_IDLE` is entered at reset and drives all phases to mid point. `ST_RUN` plays the pattern while the counter advances. `ST_HOLD` holds the end state after the period length has run out. The transitions are named as follows:
- IDLE→RUN is taken on the first strobe.
- RUN→RUN is taken on any strobe. This restarts the period.
- RUN→HOLD is taken when the counter reaches the period length minus one.
- HOLD→RUN is taken on the next strobe.

Top module: `svs_pulse_seq`

## Requirements
- R1: While reset is held, and after reset until the first strobe, all three phases read code 1 (mid point) and `seam_miss` is 0.
- R2: Phase codes are 2 = positive, 1 = mid, 0 = negative. A state word carries phase A in bits [5:4], B in [3:2] and C in [1:0], and its vector number is the sum of the three codes. The latched states are sorted by vector number into low, middle and high. The played pattern is end, middle, centre, middle, end. The end is the low or high state, and the centre is the other one.
- R3: Let E, M and C be the on-times of the end, middle and centre states. The segment lengths in cycles are floor(E/2), floor(M/2), C, M−floor(M/2) and E−floor(E/2). The first cycle after the clock edge that samples the strobe shows counter value 0.
- R4: States, on-times and period length are captured only at the strobe edge. Input changes between strobes do not change the outputs.
- R5: The first period after reset uses the low state as end. In later periods, if the previous end state equals the new high or low state, that state becomes the end. When the previous period finished on it and floor(E/2) ≥ 1, no phase changes across the boundary.
- R6: If the previous end state is neither the new low nor the new high, the end is the one nearer in vector number, with a tie going to low. `seam_miss` is 1 for that whole period and 0 otherwise.
- R7: Take three states with consecutive vector numbers where each step raises one phase. With E ≥ 2, M ≥ 2, C ≥ 1 and E+M+C equal to the period length, a full period shows exactly four level changes, and one phase never changes.
- R8: A segment with zero length occupies no cycle. The number of level changes equals the number of changes in the list of non-empty segments.
- R9: From counter value equal to the period length onward, the end state is held until the next strobe.
- R10: A strobe at any time, including mid-period, starts a new period on the next cycle.
- R11: Within a period, no phase ever steps directly between codes 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prd_start | input | 1 | Period-start strobe, one cycle |
| vec0 | input | 6 | Selected switching state, slot 0 |
| vec1 | input | 6 | Selected switching state, slot 1 |
| vec2 | input | 6 | Selected switching state, slot 2 |
| dur0 | input | CW | On-time of slot 0 in clock ticks |
| dur1 | input | CW | On-time of slot 1 in clock ticks |
| dur2 | input | CW | On-time of slot 2 in clock ticks |
| prd_len | input | CW | Period length in clock ticks |
| ph_a | output | 2 | Phase A level command |
| ph_b | output | 2 | Phase B level command |
| ph_c | output | 2 | Phase C level command |
| seam_miss | output | 1 | Previous end state was not available in this period |

## Verification
All inputs and the strobe are applied at a falling edge. They are captured at the next rising edge. The value for counter step 0, and the new `seam_miss`, appear at the falling edge right after that. Step i therefore appears i falling edges later, and the bench compares every falling edge against its model from step 0 up to the next strobe. The boundary check and the transition counts use these same sampled values. Counter values from the period length onward are expected to show the end state.

// File: rtl/svs_pkg.sv
package svs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    localparam logic [5:0] ALL_MID = 6'b01_01_01;

    function automatic logic [2:0] vnum(input logic [5:0] v);
        return {1'b0, v[5:4]} + {1'b0, v[3:2]} + {1'b0, v[1:0]};
    endfunction

endpackage

// File: rtl/svs_sorter.sv
module svs_sorter
    import svs_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [5:0]    vec_in  [3],
    input  logic [CW-1:0] dur_in  [3],
    output logic [5:0]    vec_out [3],
    output logic [CW-1:0] dur_out [3]
);

    logic [5:0]    v_w [3];
    logic [CW-1:0] d_w [3];
    logic [5:0]    v_t;
    logic [CW-1:0] d_t;

    // three compare-exchange stages: (0,1) (1,2) (0,1), stable on ties
    always_comb begin
        for (int k = 0; k < 3; k++) begin
            v_w[k] = vec_in[k];
            d_w[k] = dur_in[k];
        end
        for (int s = 0; s < 3; s++) begin
            int a;
            a = (s == 1) ? 1 : 0;
            v_t = v_w[a];
            d_t = d_w[a];
            if (vnum(v_w[a]) > vnum(v_w[a+1])) begin
                v_w[a]   = v_w[a+1];
                d_w[a]   = d_w[a+1];
                v_w[a+1] = v_t;
                d_w[a+1] = d_t;
            end
        end
        for (int k = 0; k < 3; k++) begin
            vec_out[k] = v_w[k];
            dur_out[k] = d_w[k];
        end
    end

endmodule

// File: rtl/svs_planner.sv
module svs_planner
    import svs_pkg::*;
#(
    parameter int CW = 12,
    parameter int TW = CW + 2
) (
    input  logic [5:0]    srt_vec [3],
    input  logic [CW-1:0] srt_dur [3],
    input  logic [5:0]    prev_end,
    input  logic          have_prev,
    output logic [5:0]    end_vec,
    output logic [5:0]    mid_vec,
    output logic [5:0]    ctr_vec,
    output logic [TW-1:0] thr [4],
    output logic          miss
);

    logic [2:0]    n_lo, n_hi, n_pv, dist_lo, dist_hi;
    logic          eq_lo, eq_hi, take_hi;
    logic [TW-1:0] e_len, m_len, c_len, e_half, m_half;

    always_comb begin
        n_lo    = vnum(srt_vec[0]);
        n_hi    = vnum(srt_vec[2]);
        n_pv    = vnum(prev_end);
        dist_lo = (n_pv >= n_lo) ? n_pv - n_lo : n_lo - n_pv;
        dist_hi = (n_pv >= n_hi) ? n_pv - n_hi : n_hi - n_pv;
        eq_lo   = (prev_end == srt_vec[0]);
        eq_hi   = (prev_end == srt_vec[2]);
        miss    = have_prev && !eq_lo && !eq_hi;
        if (!have_prev)  take_hi = 1'b0;
        else if (eq_hi)  take_hi = 1'b1;
        else if (eq_lo)  take_hi = 1'b0;
        else             take_hi = (dist_hi < dist_lo);
    end

    assign end_vec = take_hi ? srt_vec[2] : srt_vec[0];
    assign ctr_vec = take_hi ? srt_vec[0] : srt_vec[2];
    assign mid_vec = srt_vec[1];

    assign e_len  = {2'b00, (take_hi ? srt_dur[2] : srt_dur[0])};
    assign c_len  = {2'b00, (take_hi ? srt_dur[0] : srt_dur[2])};
    assign m_len  = {2'b00, srt_dur[1]};
    assign e_half = e_len >> 1;
    assign m_half = m_len >> 1;

    assign thr[0] = e_half;
    assign thr[1] = thr[0] + m_half;
    assign thr[2] = thr[1] + c_len;
    assign thr[3] = thr[2] + (m_len - m_half);

endmodule

// File: rtl/svs_pulse_seq.sv
module svs_pulse_seq
    import svs_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prd_start,
    input  logic [5:0]    vec0,
    input  logic [5:0]    vec1,
    input  logic [5:0]    vec2,
    input  logic [CW-1:0] dur0,
    input  logic [CW-1:0] dur1,
    input  logic [CW-1:0] dur2,
    input  logic [CW-1:0] prd_len,
    output logic [1:0]    ph_a,
    output logic [1:0]    ph_b,
    output logic [1:0]    ph_c,
    output logic          seam_miss
);

    localparam int TW = CW + 2;

    seq_state_t    state, state_nx;
    logic [CW-1:0] cnt, len_q;
    logic [5:0]    e_q, m_q, c_q, cur;
    logic [TW-1:0] thr_q [4];
    logic          have_q, last_tick;

    logic [5:0]    vin  [3];
    logic [CW-1:0] din  [3];
    logic [5:0]    vsrt [3];
    logic [CW-1:0] dsrt [3];
    logic [5:0]    e_n, m_n, c_n;
    logic [TW-1:0] thr_n [4];
    logic          miss_n;

    assign vin[0] = vec0;
    assign vin[1] = vec1;
    assign vin[2] = vec2;
    assign din[0] = dur0;
    assign din[1] = dur1;
    assign din[2] = dur2;

    svs_sorter #(.CW(CW)) i_sorter (
        .vec_in (vin),
        .dur_in (din),
        .vec_out(vsrt),
        .dur_out(dsrt)
    );

    svs_planner #(.CW(CW), .TW(TW)) i_planner (
        .srt_vec  (vsrt),
        .srt_dur  (dsrt),
        .prev_end (e_q),
        .have_prev(have_q),
        .end_vec  (e_n),
        .mid_vec  (m_n),
        .ctr_vec  (c_n),
        .thr      (thr_n),
        .miss     (miss_n)
    );

    assign last_tick = ({1'b0, cnt} + 1'b1) >= {1'b0, len_q};

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (prd_start) state_nx = ST_RUN;
            ST_RUN:  if (prd_start) state_nx = ST_RUN;
                     else if (last_tick) state_nx = ST_HOLD;
            ST_HOLD: if (prd_start) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            len_q     <= '0;
            e_q       <= ALL_MID;
            m_q       <= ALL_MID;
            c_q       <= ALL_MID;
            have_q    <= 1'b0;
            seam_miss <= 1'b0;
            for (int k = 0; k < 4; k++) thr_q[k] <= '0;
        end else if (prd_start) begin
            cnt       <= '0;
            len_q     <= prd_len;
            e_q       <= e_n;
            m_q       <= m_n;
            c_q       <= c_n;
            have_q    <= 1'b1;
            seam_miss <= miss_n;
            for (int k = 0; k < 4; k++) thr_q[k] <= thr_n[k];
        end else if (state == ST_RUN && !last_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        cur = ALL_MID;
        unique case (state)
            ST_IDLE: cur = ALL_MID;
            ST_RUN: begin
                if      ({2'b00, cnt} < thr_q[0]) cur = e_q;
                else if ({2'b00, cnt} < thr_q[1]) cur = m_q;
                else if ({2'b00, cnt} < thr_q[2]) cur = c_q;
                else if ({2'b00, cnt} < thr_q[3]) cur = m_q;
                else                              cur = e_q;
            end
            ST_HOLD: cur = e_q;
            default: cur = ALL_MID;
        endcase
    end

    assign ph_a = cur[5:4];
    assign ph_b = cur[3:2];
    assign ph_c = cur[1:0];

endmodule

// File: rtl/svs_checker.sv
module svs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       prd_start,
    input logic [1:0] ph_a,
    input logic [1:0] ph_b,
    input logic [1:0] ph_c,
    input logic       seam_miss
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen <= 1'b0;
        else if (prd_start) seen <= 1'b1;
    end

    AST_RESET_MID: assert property (@(posedge clk)
        !rst_n |-> (ph_a == 2'd1 && ph_b == 2'd1 && ph_c == 2'd1 && !seam_miss)); // R1

    AST_IDLE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (ph_a == 2'd1 && ph_b == 2'd1 && ph_c == 2'd1)); // R1

    AST_NO_RAIL_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prd_start) |->
            !((ph_a == 2'd2 && $past(ph_a) == 2'd0) || (ph_a == 2'd0 && $past(ph_a) == 2'd2) ||
              (ph_b == 2'd2 && $past(ph_b) == 2'd0) || (ph_b == 2'd0 && $past(ph_b) == 2'd2) ||
              (ph_c == 2'd2 && $past(ph_c) == 2'd0) || (ph_c == 2'd0 && $past(ph_c) == 2'd2))); // R11

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prd_start) |-> $stable(seam_miss)); // R6

endmodule

bind svs_pulse_seq svs_checker i_svs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .prd_start(prd_start),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .ph_c     (ph_c),
    .seam_miss(seam_miss)
);

// File: tb/test_svs_pulse_seq.sv
`timescale 1ns/1ps
module test_svs_pulse_seq;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prd_start = 1'b0;
    logic [5:0]    vec0 = 6'b01_01_01, vec1 = 6'b01_01_01, vec2 = 6'b01_01_01;
    logic [CW-1:0] dur0 = '0, dur1 = '0, dur2 = '0, prd_len = '0;
    logic [1:0]    ph_a, ph_b, ph_c;
    logic          seam_miss;

    always #10 clk = ~clk;

    svs_pulse_seq #(.CW(CW)) i_svs_pulse_seq (
        .clk(clk), .rst_n(rst_n), .prd_start(prd_start),
        .vec0(vec0), .vec1(vec1), .vec2(vec2),
        .dur0(dur0), .dur1(dur1), .dur2(dur2), .prd_len(prd_len),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .seam_miss(seam_miss)
    );

    int         n_chk = 0, n_bad = 0;
    bit         done = 0;
    bit         b_have = 0;
    logic [5:0] b_prev = 6'b01_01_01;
    logic [5:0] b_last = 6'b01_01_01;

    function automatic int vn(logic [5:0] v);
        return int'(v[5:4]) + int'(v[3:2]) + int'(v[1:0]);
    endfunction

    function automatic int lv(logic [5:0] v, int k);
        return int'(v[5-2*k -: 2]);
    endfunction

    function automatic logic [5:0] setlv(logic [5:0] v, int k, int x);
        logic [5:0] r;
        r = v;
        r[5-2*k -: 2] = 2'(x);
        return r;
    endfunction

    function automatic logic [5:0] seg_at(int i, int len, int de, int dm, int dc,
                                          logic [5:0] e, logic [5:0] m, logic [5:0] c);
        int t1, t2, t3, t4;
        t1 = de / 2;
        t2 = t1 + dm / 2;
        t3 = t2 + dc;
        t4 = t3 + dm - dm / 2;
        if (i >= len) return e;
        if (i < t1)   return e;
        if (i < t2)   return m;
        if (i < t3)   return c;
        if (i < t4)   return m;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // random triangle of three consecutive states, each step raises one phase
    task automatic gen_tri(output logic [5:0] s0, output logic [5:0] s1, output logic [5:0] s2);
        bit ok = 0;
        while (!ok) begin
            int i, j;
            s0 = {2'($urandom_range(2)), 2'($urandom_range(2)), 2'($urandom_range(2))};
            i = $urandom_range(2);
            j = $urandom_range(2);
            if (i != j && lv(s0, i) < 2 && lv(s0, j) < 2) begin
                s1 = setlv(s0, i, lv(s0, i) + 1);
                s2 = setlv(s1, j, lv(s1, j) + 1);
                ok = 1;
            end
        end
    endtask

    // triangle that has p as its low or high state
    task automatic gen_from(input logic [5:0] p, output logic [5:0] s0,
                            output logic [5:0] s1, output logic [5:0] s2);
        bit ok = 0;
        while (!ok) begin
            int i, j;
            bit up;
            i  = $urandom_range(2);
            j  = $urandom_range(2);
            up = 1'($urandom_range(1));
            if (i != j) begin
                if (up && lv(p, i) < 2 && lv(p, j) < 2) begin
                    s0 = p;
                    s1 = setlv(p, i, lv(p, i) + 1);
                    s2 = setlv(s1, j, lv(s1, j) + 1);
                    ok = 1;
                end else if (!up && lv(p, i) > 0 && lv(p, j) > 0) begin
                    s2 = p;
                    s1 = setlv(p, i, lv(p, i) - 1);
                    s0 = setlv(s1, j, lv(s1, j) - 1);
                    ok = 1;
                end
            end
        end
    endtask

    // called just after a falling edge; returns just after a falling edge
    task automatic run_period(input logic [5:0] a0, input logic [5:0] a1, input logic [5:0] a2,
                              input int q0, input int q1, input int q2,
                              input int len, input int ncyc, input bit scr);
        logic [5:0] sv [3];
        int         sq [3];
        logic [5:0] e, m, c, obs, expv, prevobs, exp_prev;
        int         de, dm, dc, dl, dh, n_obs, n_exp;
        bit         exp_miss, hi_end, tail_e, have0;
        logic [2:0] moved;
        sv[0] = a0; sv[1] = a1; sv[2] = a2;
        sq[0] = q0; sq[1] = q1; sq[2] = q2;
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 2 - p; k++) begin
                if (vn(sv[k]) > vn(sv[k+1])) begin
                    logic [5:0] tv; int tq;
                    tv = sv[k]; sv[k] = sv[k+1]; sv[k+1] = tv;
                    tq = sq[k]; sq[k] = sq[k+1]; sq[k+1] = tq;
                end
            end
        end
        exp_miss = 0;
        hi_end   = 0;
        have0    = b_have;
        tail_e   = b_have && (b_last == b_prev);
        if (b_have) begin
            if (b_prev == sv[2])      hi_end = 1;
            else if (b_prev == sv[0]) hi_end = 0;
            else begin
                exp_miss = 1;
                dl = vn(b_prev) - vn(sv[0]); if (dl < 0) dl = -dl;
                dh = vn(b_prev) - vn(sv[2]); if (dh < 0) dh = -dh;
                hi_end = (dh < dl);
            end
        end
        e  = hi_end ? sv[2] : sv[0];
        c  = hi_end ? sv[0] : sv[2];
        m  = sv[1];
        de = hi_end ? sq[2] : sq[0];
        dc = hi_end ? sq[0] : sq[2];
        dm = sq[1];

        vec0 = a0; vec1 = a1; vec2 = a2;
        dur0 = CW'(q0); dur1 = CW'(q1); dur2 = CW'(q2);
        prd_len = CW'(len);
        prd_start = 1'b1;
        @(negedge clk);
        prd_start = 1'b0;
        if (scr) begin
            // R4: scrambled inputs between strobes must not matter
            vec0 = 6'($urandom); vec1 = 6'($urandom); vec2 = 6'($urandom);
            dur0 = CW'($urandom_range(30)); dur1 = CW'($urandom_range(30));
            dur2 = CW'($urandom_range(30)); prd_len = CW'($urandom_range(40));
        end
        chk(seam_miss == exp_miss, "R6 seam flag", int'(seam_miss), int'(exp_miss));
        n_obs = 0; n_exp = 0; moved = '0;
        prevobs = {ph_a, ph_b, ph_c};
        exp_prev = seg_at(0, len, de, dm, dc, e, m, c);
        for (int i = 0; i < ncyc; i++) begin
            if (i > 0) @(negedge clk);
            obs  = {ph_a, ph_b, ph_c};
            expv = seg_at(i, len, de, dm, dc, e, m, c);
            chk(obs == expv, (scr ? "R4 latched pattern" : (ncyc > len ? "R9 hold / R3 segment" :
                (ncyc < len ? "R10 restart / R3 segment" : "R2 order / R3 segment"))),
                int'(obs), int'(expv));
            if (i == 0) begin
                if (have0 && tail_e && !exp_miss && de >= 2)
                    chk(obs == b_last, "R5 seamless boundary", int'(obs), int'(b_last));
            end else begin
                if (obs != prevobs) n_obs++;
                if (expv != exp_prev) n_exp++;
                for (int k = 0; k < 3; k++)
                    if (lv(obs, k) != lv(prevobs, k)) moved[k] = 1'b1;
            end
            prevobs  = obs;
            exp_prev = expv;
        end
        if (ncyc == len && de + dm + dc == len) begin
            if (de >= 2 && dm >= 2 && dc >= 1) begin
                chk(n_obs == 4, "R7 four transitions", n_obs, 4);
                chk(moved != 3'b111, "R7 one phase steady", int'(moved), 0);
            end else begin
                chk(n_obs == n_exp, "R8 zero-length segments", n_obs, n_exp);
            end
        end
        b_have = 1;
        b_prev = e;
        b_last = prevobs;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] s0, s1, s2;
        void'($urandom(32'd2024));
        repeat (3) begin
            @(negedge clk);
            chk({ph_a, ph_b, ph_c} == 6'b01_01_01 && !seam_miss, "R1 reset level",
                int'({ph_a, ph_b, ph_c}), 'h15);
        end
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            vec0 = 6'($urandom); dur0 = CW'($urandom_range(9)); prd_len = CW'($urandom_range(9));
            chk({ph_a, ph_b, ph_c} == 6'b01_01_01 && !seam_miss, "R1 idle level",
                int'({ph_a, ph_b, ph_c}), 'h15);
        end
        @(negedge clk);
        // directed first period: slots hold OON, PON, ONN
        run_period(6'b01_01_00, 6'b10_01_00, 6'b01_00_00, 4, 4, 6, 14, 14, 0);
        // R5: new set built around previous end state
        gen_from(b_prev, s0, s1, s2);
        run_period(s1, s2, s0, 6, 5, 7, 18, 18, 0);
        // R6: set that cannot contain the previous end
        run_period(6'b10_10_01, 6'b10_01_01, 6'b10_10_10, 4, 6, 4, 14, 14, 0);
        // R8: zero-length segments in each slot
        gen_from(b_prev, s0, s1, s2);
        run_period(s0, s1, s2, 0, 6, 6, 12, 12, 0);
        gen_from(b_prev, s0, s1, s2);
        run_period(s0, s1, s2, 6, 0, 6, 12, 12, 0);
        gen_from(b_prev, s0, s1, s2);
        run_period(s0, s1, s2, 6, 6, 0, 12, 12, 0);
        // R9: period longer than the on-times, then extra hold cycles
        gen_from(b_prev, s0, s1, s2);
        run_period(s0, s1, s2, 4, 4, 4, 16, 22, 0);
        // R10: restart half way, with scrambled inputs (R4)
        gen_from(b_prev, s0, s1, s2);
        run_period(s0, s1, s2, 8, 8, 8, 24, 11, 1);
        gen_tri(s0, s1, s2);
        run_period(s2, s0, s1, 5, 5, 5, 15, 15, 1);
        for (int n = 0; n < 150; n++) begin
            int len, q0, q1, q2, nc, pick;
            bit scr;
            if ($urandom_range(1) == 1) gen_from(b_prev, s0, s1, s2);
            else gen_tri(s0, s1, s2);
            len = 6 + $urandom_range(34);
            q0  = $urandom_range(len);
            q1  = $urandom_range(len - q0);
            q2  = len - q0 - q1;
            pick = $urandom_range(9);
            nc  = (pick == 0) ? len / 2 + 1 : ((pick == 1) ? len + 3 : len);
            scr = ($urandom_range(3) == 0);
            case ($urandom_range(2))
                0: run_period(s0, s1, s2, q0, q1, q2, len, nc, scr);
                1: run_period(s2, s0, s1, q0, q1, q2, len, nc, scr);
                default: run_period(s1, s2, s0, q0, q1, q2, len, nc, scr);
            endcase
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule